// File: doc/BRIEF.md
# Sixteen-bit capture/reload timer

This block is a 16-bit timer/counter that sits behind a small byte-wide register port. Each count step comes from one of two sources. The first is a prescaled system clock, which gives one step every four or every twelve clocks. The second is a qualified falling edge on an external count pin. A second external pin, the strobe, can trigger one of two actions: it copies the running count into the capture/reload register, or it reloads the count from that register.

Four behaviours are chosen through the control and mode registers:
- **Capture:** the count wraps freely, and strobe edges take snapshots of it.
- **Reload, upward:** an overflow, or a strobe edge, loads the count from the reload value.
- **Reload, up or down:** the strobe level chooses the direction, and the reload register acts as the lower turning point.
- **Baud generation:** every overflow reloads the count and sends a single-cycle tick to a serial transmitter or receiver. The overflow flag stays quiet in this mode.

Both external pins pass through the same synchronizing sampler. A falling edge counts only if the sampler sees the pin low on two consecutive samples after it was high.

Top module: `cap_reload_timer`

Register addresses (reg_addr): 0 count bits 7:0, 1 count bits 15:8, 2 capture/reload bits 7:0, 3 capture/reload bits 15:8, 4 control, 5 mode.
Control bits: 0 run, 1 external count source, 2 strobe enable, 3 capture select, 4 transmit baud select, 5 receive baud select, 6 strobe flag, 7 overflow flag.
Mode bits: 0 up/down enable, 1 clear count on capture, 2 fast prescale (1 = divide by 4, 0 = divide by 12). Bits 7:3 of the mode register read as 0.

## Requirements
- R1: After reset, all six registers read 0x00 and baud_tick is low.
- R2: Writing any of the six registers stores the written value at its address, and a read returns it. The mode register keeps only bits 2:0.
- R3: With control bit 0 set and control bit 1 clear, the count advances once every 4 clocks when mode bit 2 is 1, and once every 12 clocks when mode bit 2 is 0. With control bit 0 clear, the count holds.
- R4: With control bit 1 set, the count advances once for each fall of cnt_pin that stays low for at least two clocks. A low pulse lasting a single clock is not counted.
- R5: In capture mode (control bit 3 = 1), a qualified fall of strb_pin behaves as follows. With control bit 2 set, it copies the count into the capture/reload register and sets control bit 6. With control bit 2 clear, it changes neither the register, the count nor the flag.
- R6: With mode bit 1 set, a strobe capture also clears the count to 0x0000.
- R7: In upward reload mode (control bits 3, 4 and 5 clear, mode bit 0 clear), a step taken at 0xFFFF loads the reload value and sets control bit 7. An enabled strobe fall loads the reload value and sets control bit 6.
- R8: In capture mode, a step taken at 0xFFFF wraps the count to 0x0000 and sets control bit 7.
- R9: In up/down mode (mode bit 0 = 1, control bit 3 = 0), the strobe direction follows the strobe level: high counts up, low counts down. Counting down, a step taken when the count equals the reload value loads 0xFFFF. Counting up, a step taken at 0xFFFF loads the reload value. Both events set control bit 7. Control bit 6 is never set in this mode.
- R10: When control bit 4 or control bit 5 is set, the count runs upward and reloads on overflow. baud_tick pulses high for exactly one clock per overflow, and control bit 7 is not set.
- R11: A write to the control register sets or clears flag bits 6 and 7 exactly as written.
- R12: When a count step and a strobe capture fall in the same clock, the capture register receives the count from before the step. The count becomes that value plus one, or 0x0000 if mode bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cnt_pin | input | 1 | External count source, counted on falling edges |
| strb_pin | input | 1 | External strobe, edge for capture or reload, level for direction |
| ovf_flag | output | 1 | Overflow flag (control bit 7) |
| ext_flag | output | 1 | Strobe flag (control bit 6) |
| baud_tick | output | 1 | One-clock pulse on each overflow in baud mode |

## Verification
Two things can happen in the same clock: a count step and a strobe capture. The bench makes them coincide by running in external-count mode and driving cnt_pin and strb_pin low in the same instant. Both pins pass through identical samplers, so their edges are qualified in the same cycle. The result is judged by whether the capture register holds the count from before the step. The count must then read one higher, or zero when clear-on-capture is set.

// File: rtl/timer_pkg.sv
package timer_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    localparam logic [2:0] A_CNT_LO = 3'd0;
    localparam logic [2:0] A_CNT_HI = 3'd1;
    localparam logic [2:0] A_CRL_LO = 3'd2;
    localparam logic [2:0] A_CRL_HI = 3'd3;
    localparam logic [2:0] A_CTRL   = 3'd4;
    localparam logic [2:0] A_MODE   = 3'd5;

    typedef struct packed {
        logic ovf;
        logic ext;
        logic rx_baud;
        logic tx_baud;
        logic cap_sel;
        logic strb_en;
        logic cnt_sel;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic fast;
        logic clr_cap;
        logic updown;
    } mode_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] crl;
        ctrl_t            ctrl;
        mode_t            mode;
        logic             baud;
    } tmr_state_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [PW-1:0] div_d, div_q;
    logic [PW-1:0] limit;

    always_comb begin
        limit = fast ? PW'(FAST_DIV - 1) : PW'(SLOW_DIV - 1);
        tick  = run && (div_q == limit);
        if (!run || tick) begin
            div_d = '0;
        end else begin
            div_d = div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tmr_pin_sampler.sv
module tmr_pin_sampler #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic fall
);
    localparam int LEN = SYNC + 2;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d  = {sh_q[LEN-2:0], pin};
        level = sh_q[SYNC-1];
        fall  = sh_q[SYNC+1] & ~sh_q[SYNC] & ~sh_q[SYNC-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import timer_pkg::*;
#(
    parameter int FAST_DIV    = 4,
    parameter int SLOW_DIV    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cnt_pin,
    input  logic       strb_pin,
    output logic       ovf_flag,
    output logic       ext_flag,
    output logic       baud_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int NPIN = 2;

    tmr_state_t s_d, s_q;

    logic [NPIN-1:0] pin_in, pin_lvl, pin_fall;
    logic pre_tick, tick, baud_mode, at_max, strb_hit;
    logic set_ovf, set_ext, cap_load, cnt_wr;

    assign pin_in = {strb_pin, cnt_pin};

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        tmr_pin_sampler #(.SYNC(SYNC_STAGES)) i_samp (
            .clk  (clk),
            .rst  (rst),
            .pin  (pin_in[g]),
            .level(pin_lvl[g]),
            .fall (pin_fall[g])
        );
    end

    tmr_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) i_pre (
        .clk (clk),
        .rst (rst),
        .run (s_q.ctrl.run),
        .fast(s_q.mode.fast),
        .tick(pre_tick)
    );

    always_comb begin
        s_d       = s_q;
        s_d.baud  = 1'b0;
        set_ovf   = 1'b0;
        set_ext   = 1'b0;
        cap_load  = 1'b0;
        tick      = s_q.ctrl.run & (s_q.ctrl.cnt_sel ? pin_fall[0] : pre_tick);
        baud_mode = s_q.ctrl.tx_baud | s_q.ctrl.rx_baud;
        at_max    = (s_q.cnt == CNT_MAX);
        strb_hit  = pin_fall[1] & s_q.ctrl.strb_en;
        cnt_wr    = reg_wr && (reg_addr == A_CNT_LO || reg_addr == A_CNT_HI);

        if (baud_mode) begin
            if (tick) begin
                if (at_max) begin
                    s_d.cnt  = s_q.crl;
                    s_d.baud = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end else if (s_q.ctrl.cap_sel) begin
            if (tick) begin
                s_d.cnt = s_q.cnt + 1'b1;
                set_ovf = at_max;
            end
            if (strb_hit) begin
                s_d.crl  = s_q.cnt;
                cap_load = 1'b1;
                set_ext  = 1'b1;
                if (s_q.mode.clr_cap) begin
                    s_d.cnt = '0;
                end
            end
        end else if (s_q.mode.updown) begin
            if (tick) begin
                if (pin_lvl[1]) begin
                    if (at_max) begin
                        s_d.cnt = s_q.crl;
                        set_ovf = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end else if (s_q.cnt == s_q.crl) begin
                    s_d.cnt = CNT_MAX;
                    set_ovf = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end else begin
            if (tick) begin
                if (at_max) begin
                    s_d.cnt = s_q.crl;
                    set_ovf = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (strb_hit) begin
                s_d.cnt = s_q.crl;
                set_ext = 1'b1;
            end
        end

        if (reg_wr) begin
            case (reg_addr)
                A_CNT_LO: s_d.cnt = {s_q.cnt[CNT_W-1:BYTE_W], reg_wdata};
                A_CNT_HI: s_d.cnt = {reg_wdata, s_q.cnt[BYTE_W-1:0]};
                A_CRL_LO: if (!cap_load) s_d.crl = {s_q.crl[CNT_W-1:BYTE_W], reg_wdata};
                A_CRL_HI: if (!cap_load) s_d.crl = {reg_wdata, s_q.crl[BYTE_W-1:0]};
                A_CTRL:   s_d.ctrl = ctrl_t'(reg_wdata);
                A_MODE:   s_d.mode = mode_t'(reg_wdata[2:0]);
                default:  ;
            endcase
        end
        s_d.ctrl.ovf = s_d.ctrl.ovf | set_ovf;
        s_d.ctrl.ext = s_d.ctrl.ext | set_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_CNT_LO: reg_rdata = s_q.cnt[BYTE_W-1:0];
            A_CNT_HI: reg_rdata = s_q.cnt[CNT_W-1:BYTE_W];
            A_CRL_LO: reg_rdata = s_q.crl[BYTE_W-1:0];
            A_CRL_HI: reg_rdata = s_q.crl[CNT_W-1:BYTE_W];
            A_CTRL:   reg_rdata = s_q.ctrl;
            A_MODE:   reg_rdata = {5'b0, s_q.mode};
            default:  reg_rdata = '0;
        endcase
    end

    assign ovf_flag  = s_q.ctrl.ovf;
    assign ext_flag  = s_q.ctrl.ext;
    assign baud_tick = s_q.baud;

    p_hold_when_stopped_r3: assert property (@(posedge clk) disable iff (rst)
        (!s_q.ctrl.run && !cnt_wr && !(strb_hit && !baud_mode && !s_q.mode.updown)
         && !(strb_hit && s_q.ctrl.cap_sel)) |=> $stable(s_q.cnt));

    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (s_q.ctrl.run && !s_q.ctrl.cnt_sel && s_q.ctrl.cap_sel && !baud_mode
         && pre_tick && !at_max && !strb_hit && !cnt_wr)
        |=> (s_q.cnt == $past(s_q.cnt) + 16'd1));

    p_ext_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
        (!s_q.ctrl.strb_en && !s_q.ctrl.ext && !(reg_wr && reg_addr == A_CTRL))
        |=> !s_q.ctrl.ext);

    p_reload_on_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && at_max && !baud_mode && !s_q.ctrl.cap_sel && !s_q.mode.updown
         && !strb_hit && !cnt_wr) |=> (s_q.cnt == $past(s_q.crl) && s_q.ctrl.ovf));

    p_baud_no_ovf_r10: assert property (@(posedge clk) disable iff (rst)
        (baud_mode && !s_q.ctrl.ovf && !(reg_wr && reg_addr == A_CTRL)) |=> !s_q.ctrl.ovf);

    p_baud_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);
endmodule

// File: tb/test_cap_reload_timer.sv
module test_cap_reload_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cnt_pin = 1'b1;
    logic       strb_pin = 1'b1;
    logic       ovf_flag, ext_flag, baud_tick;

    int tests = 0;
    int fails = 0;
    logic [15:0] v16;

    cap_reload_timer i_cap_reload_timer (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_pin(cnt_pin),
        .strb_pin(strb_pin), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .baud_tick(baud_tick)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] a_lo, input logic [15:0] d);
        wr(a_lo, d[7:0]);
        wr(a_lo + 3'd1, d[15:8]);
    endtask

    task automatic rd8(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic rd16(input logic [2:0] a_lo, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd8(a_lo, lo);
        rd8(a_lo + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe_pulse(input logic both);
        @(negedge clk);
        strb_pin = 1'b0;
        if (both) cnt_pin = 1'b0;
        wait_n(6);
        strb_pin = 1'b1; cnt_pin = 1'b1;
        wait_n(4);
    endtask

    task automatic cnt_pulse(input int low_len);
        @(negedge clk);
        cnt_pin = 1'b0;
        wait_n(low_len);
        cnt_pin = 1'b1;
        wait_n(4);
    endtask

    initial begin
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd8(3'(a), b);
            check("R1 reset reg", {8'h0, b}, 16'h0000);
        end
        check("R1 baud_tick", {15'h0, baud_tick}, 16'h0000);

        // R2 register access
        wr16(3'd0, 16'hA55A);
        wr16(3'd2, 16'hC33C);
        rd16(3'd0, v16); check("R2 count", v16, 16'hA55A);
        rd16(3'd2, v16); check("R2 crl", v16, 16'hC33C);
        wr(3'd5, 8'hFF);
        rd8(3'd5, b); check("R2 mode", {8'h0, b}, 16'h0007);
        wr(3'd4, 8'h08);
        rd8(3'd4, b); check("R2 ctrl", {8'h0, b}, 16'h0008);

        // R3 prescaled timer, fast and slow, sweep
        for (int f = 0; f < 2; f++) begin
            wr16(3'd0, 16'h0100);
            wr(3'd5, f == 0 ? 8'h04 : 8'h00);
            wr(3'd4, 8'h09);
            for (int m = 0; m < 48; m++) begin
                if (m > 0) @(negedge clk);
                rd16(3'd0, v16);
                check("R3 timer rate", v16, 16'h0100 + 16'(m / (f == 0 ? 4 : 12)));
            end
            wr(3'd4, 8'h08);
            rd16(3'd0, v16);
            wait_n(30);
            begin
                logic [15:0] v2;
                rd16(3'd0, v2);
                check("R3 hold stopped", v2, v16);
            end
        end

        // R8 capture-mode wrap
        wr16(3'd0, 16'hFFFE);
        wr(3'd5, 8'h04);
        wr(3'd4, 8'h09);
        wait_n(8);
        rd16(3'd0, v16); check("R8 wrap count", v16, 16'h0000);
        rd8(3'd4, b); check("R8 ovf flag", {8'h0, b}, 16'h0089);
        // R11 software clears and sets flags
        wr(3'd4, 8'h08);
        rd8(3'd4, b); check("R11 clear", {8'h0, b}, 16'h0008);
        check("R11 ovf pin", {15'h0, ovf_flag}, 16'h0000);
        wr(3'd4, 8'hC8);
        rd8(3'd4, b); check("R11 set", {8'h0, b}, 16'h00C8);
        wr(3'd4, 8'h00);

        // R7 upward reload
        wr16(3'd2, 16'h1234);
        wr16(3'd0, 16'hFFF0);
        wr(3'd4, 8'h01);
        for (int m = 1; m <= 68; m++) begin
            @(negedge clk);
            if (m == 60 || m == 64 || m == 68) begin
                rd16(3'd0, v16);
                check("R7 overflow reload", v16,
                      m == 60 ? 16'hFFFF : (m == 64 ? 16'h1234 : 16'h1235));
            end
        end
        rd8(3'd4, b); check("R7 ovf flag", {8'h0, b}, 16'h0081);
        wr(3'd4, 8'h04);
        wr16(3'd0, 16'h0042);
        strobe_pulse(1'b0);
        rd16(3'd0, v16); check("R7 strobe reload", v16, 16'h1234);
        rd8(3'd4, b); check("R7 ext flag", {8'h0, b}, 16'h0044);

        // R5 capture by strobe
        wr(3'd4, 8'h0C);
        wr16(3'd0, 16'h0777);
        strobe_pulse(1'b0);
        rd16(3'd2, v16); check("R5 capture", v16, 16'h0777);
        rd8(3'd4, b); check("R5 ext flag", {8'h0, b}, 16'h004C);
        wr(3'd4, 8'h08);
        wr16(3'd0, 16'h0888);
        strobe_pulse(1'b0);
        rd16(3'd2, v16); check("R5 disabled no capture", v16, 16'h0777);
        rd16(3'd0, v16); check("R5 disabled count", v16, 16'h0888);
        rd8(3'd4, b); check("R5 disabled flag", {8'h0, b}, 16'h0008);

        // R6 clear on capture
        wr(3'd5, 8'h02);
        wr(3'd4, 8'h0C);
        wr16(3'd0, 16'h0999);
        strobe_pulse(1'b0);
        rd16(3'd2, v16); check("R6 capture", v16, 16'h0999);
        rd16(3'd0, v16); check("R6 cleared", v16, 16'h0000);

        // R4 external count pin
        wr(3'd5, 8'h00);
        wr16(3'd0, 16'h0000);
        wr(3'd4, 8'h0B);
        for (int p = 1; p <= 5; p++) begin
            cnt_pulse(3);
            rd16(3'd0, v16); check("R4 edge count", v16, 16'(p));
        end
        for (int p = 0; p < 3; p++) begin
            cnt_pulse(1);
            rd16(3'd0, v16); check("R4 glitch ignored", v16, 16'd5);
        end
        for (int p = 1; p <= 2; p++) begin
            cnt_pulse(2);
            rd16(3'd0, v16); check("R4 two-sample edge", v16, 16'(5 + p));
        end

        // R12 step and capture in the same cycle
        wr16(3'd0, 16'h0020);
        wr(3'd4, 8'h0F);
        strobe_pulse(1'b1);
        rd16(3'd2, v16); check("R12 capture pre-step", v16, 16'h0020);
        rd16(3'd0, v16); check("R12 count stepped", v16, 16'h0021);
        check("R12 ext flag", {15'h0, ext_flag}, 16'h0001);
        wr(3'd5, 8'h02);
        wr16(3'd0, 16'h0030);
        wr(3'd4, 8'h0F);
        strobe_pulse(1'b1);
        rd16(3'd2, v16); check("R12 capture with clear", v16, 16'h0030);
        rd16(3'd0, v16); check("R12 clear wins", v16, 16'h0000);

        // R9 up/down
        wr(3'd4, 8'h00);
        @(negedge clk); strb_pin = 1'b0;
        wait_n(6);
        wr(3'd5, 8'h05);
        wr16(3'd2, 16'h0010);
        wr16(3'd0, 16'h0014);
        wr(3'd4, 8'h05);
        for (int m = 1; m <= 24; m++) begin
            @(negedge clk);
            if (m % 4 == 0) begin
                rd16(3'd0, v16);
                check("R9 down count", v16, m <= 16 ? 16'h0014 - 16'(m / 4)
                      : (m == 20 ? 16'hFFFF : 16'hFFFE));
            end
        end
        rd8(3'd4, b); check("R9 down flags", {8'h0, b}, 16'h0085);
        wr(3'd4, 8'h04);
        wr16(3'd0, 16'hFFFE);
        @(negedge clk); strb_pin = 1'b1;
        wait_n(6);
        wr(3'd4, 8'h05);
        wait_n(4);
        rd16(3'd0, v16); check("R9 up count", v16, 16'hFFFF);
        wait_n(4);
        rd16(3'd0, v16); check("R9 up reload", v16, 16'h0010);
        rd8(3'd4, b); check("R9 up flags", {8'h0, b}, 16'h0085);

        // R10 baud generation, transmit then receive select
        for (int k = 0; k < 2; k++) begin
            int pulses;
            wr(3'd4, 8'h00);
            wr(3'd5, 8'h04);
            wr16(3'd2, 16'hFFFC);
            wr16(3'd0, 16'hFFFC);
            wr(3'd4, k == 0 ? 8'h11 : 8'h21);
            pulses = 0;
            for (int m = 0; m < 160; m++) begin
                @(negedge clk);
                if (baud_tick) pulses++;
            end
            check("R10 baud pulses", 16'(pulses), 16'd10);
            rd8(3'd4, b); check("R10 no ovf", {8'h0, b}, k == 0 ? 16'h0011 : 16'h0021);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule